// File: doc/BRIEF.md
# SPI Command Sequencer

This block is a half-duplex SPI master driven through a small register window. Software writes a command byte, a count of bytes to send after it, a count of bytes to collect back, and the index of the target device. It places the outgoing bytes in a shared byte buffer and then sets a start bit. From that point the hardware works alone. It lowers the chosen chip select, sends the command byte, sends the outgoing bytes, and then clocks in the requested number of reply bytes. The reply bytes are written into the same buffer, directly after the outgoing ones. A busy flag drops when the chip select has been released, and software polls that flag for completion.

The buffer has one internal pointer. The engine fetches outgoing bytes from the pointer and stores reply bytes at the pointer, advancing it after each byte. A software-issued pointer clear sends it back to the start of the buffer. Without a clear, the next command continues from where the previous one stopped. The serial clock runs in mode 0, most significant bit first, at one quarter of the system clock.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, every chip select is high, the serial clock is low, and the control word (byte offset 0x00) and the count word (byte offset 0x48) both read as zero.
- R2: The command byte reads back from control bits [7:0], the device index from bits [9:8] of the word at 0x1C, the send count from bits [7:0] of the word at 0x48, and the reply count from bits [31:24] of that word. The start bit (16) and the clear bit (20) always read as 0.
- R3: Writing 1 to control bit 16 while idle sets control bit 31, which stays 1 until the command has finished. A start written while bit 31 is 1 is ignored: no further bits go out, and the running command keeps the command byte it started with.
- R4: Bytes go out in this order: the command byte, then the send-count bytes taken from the buffer at the pointer, each byte MSB first. The data line changes only while the serial clock is low, and it is held low during the reply phase.
- R5: The serial clock idles low. Each bit takes 4 system clocks: 2 low, then 2 high. A command of N bytes gives exactly 8*N rising edges and keeps the chip select low for 8+32*N system clocks.
- R6: Reply bits are sampled on the rising clock edges, MSB first. Each reply byte is stored at the current pointer, so after a pointer clear the replies land at buffer index equal to the send count.
- R7: For the whole command, only the chip select picked by the device index is low. All others stay high, and all are high when idle.
- R8: Writing 1 to control bit 20 while idle resets the pointer to buffer index 0. Without a clear, a command starts at the pointer left behind by the previous command, which is the previous start point plus its send and reply counts.
- R9: A reply count of zero ends the command after the last sent byte, and no buffer byte is written. A send count of zero goes from the command byte straight to the reply phase.
- R10: Buffer bytes are addressed from 0x80 upward, four per aligned word, byte lane k holding byte address +k. Only lanes whose byte enable is set are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address; only word-aligned accesses take effect |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The hardest cases to reach through the ports involve state carried from one command to the next. The pointer continuing after a command without a clear is one. A start that arrives in the middle of a running command is the other. The bench first runs a command that leaves the pointer at index 5 and plants a marker byte there through a single-lane write. It then starts a second command without a clear and checks that the marker is sent and the reply lands just after it. For the ignored start, the bench fires a second start with a new command byte ten cycles into a command that has only a command byte. A device model on the serial pins counts the rising edges and captures every data bit, so any extra byte or changed command byte shows up in those records.

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int FIFO_BYTES = 64,
  parameter int NUM_CS     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam int PW  = $clog2(FIFO_BYTES);
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam logic [4:0] W_CTRL = 5'd0;
  localparam logic [4:0] W_CSEL = 5'd7;
  localparam logic [4:0] W_CNT  = 5'd18;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_XFER, S_TAIL} state_t;

  state_t          state_q;
  logic [1:0]      phase_q;
  logic [2:0]      bit_q;
  logic            rd_q;
  logic [7:0]      sh_q;
  logic [7:0]      tx_left_q, rx_left_q;
  logic [PW-1:0]   ptr_q;
  logic [CSW-1:0]  cs_act_q, cs_sel_q;
  logic [7:0]      opcode_q, tx_cnt_q, rx_cnt_q;
  logic [7:0]      fifo_mem [FIFO_BYTES];

  wire        aligned   = (bus_addr[1:0] == 2'b00);
  wire        wr_en     = bus_sel & bus_wr & aligned;
  wire        in_fifo   = bus_addr[7];
  wire [4:0]  word      = bus_addr[6:2];
  wire        ctrl_hit  = wr_en & ~in_fifo & (word == W_CTRL);
  wire        csel_hit  = wr_en & ~in_fifo & (word == W_CSEL);
  wire        cnt_hit   = wr_en & ~in_fifo & (word == W_CNT);
  wire        start_req = ctrl_hit & bus_be[2] & bus_wdata[16];
  wire        clr_req   = ctrl_hit & bus_be[2] & bus_wdata[20];

  logic busy;
  assign busy = (state_q != S_IDLE);

  wire        start_go = start_req & ~busy;
  wire [7:0]  opc_now  = (ctrl_hit & bus_be[0]) ? bus_wdata[7:0] : opcode_q;
  wire        eng_we   = (state_q == S_XFER) && (phase_q == 2'd3) && (bit_q == 3'd0) && rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q <= '0;
      tx_cnt_q <= '0;
      rx_cnt_q <= '0;
      cs_sel_q <= '0;
    end else begin
      if (ctrl_hit && bus_be[0]) opcode_q <= bus_wdata[7:0];
      if (csel_hit && bus_be[1]) cs_sel_q <= bus_wdata[8 +: CSW];
      if (cnt_hit && bus_be[0])  tx_cnt_q <= bus_wdata[7:0];
      if (cnt_hit && bus_be[3])  rx_cnt_q <= bus_wdata[31:24];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && in_fifo) begin
      for (int l = 0; l < 4; l++) begin
        if (bus_be[l]) fifo_mem[PW'({bus_addr[6:2], 2'b00} + l)] <= bus_wdata[8*l +: 8];
      end
    end
    if (eng_we) fifo_mem[ptr_q] <= sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      phase_q   <= '0;
      bit_q     <= 3'd7;
      rd_q      <= 1'b0;
      sh_q      <= '0;
      tx_left_q <= '0;
      rx_left_q <= '0;
      ptr_q     <= '0;
      cs_act_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (clr_req) ptr_q <= '0;
          if (start_go) begin
            state_q   <= S_LEAD;
            phase_q   <= '0;
            bit_q     <= 3'd7;
            rd_q      <= 1'b0;
            sh_q      <= opc_now;
            tx_left_q <= tx_cnt_q;
            rx_left_q <= rx_cnt_q;
            cs_act_q  <= cs_sel_q;
          end
        end
        S_LEAD: begin
          phase_q <= phase_q + 2'd1;
          if (phase_q == 2'd3) state_q <= S_XFER;
        end
        S_XFER: begin
          phase_q <= phase_q + 2'd1;
          if (phase_q == 2'd1 && rd_q) sh_q <= {sh_q[6:0], spi_miso};
          if (phase_q == 2'd3) begin
            if (bit_q != 3'd0) begin
              bit_q <= bit_q - 3'd1;
              if (!rd_q) sh_q <= {sh_q[6:0], 1'b0};
            end else begin
              bit_q <= 3'd7;
              if (rd_q) begin
                ptr_q     <= ptr_q + PW'(1);
                rx_left_q <= rx_left_q - 8'd1;
                if (rx_left_q == 8'd1) state_q <= S_TAIL;
              end else if (tx_left_q != 8'd0) begin
                sh_q      <= fifo_mem[ptr_q];
                ptr_q     <= ptr_q + PW'(1);
                tx_left_q <= tx_left_q - 8'd1;
              end else if (rx_left_q != 8'd0) begin
                rd_q <= 1'b1;
                sh_q <= '0;
              end else begin
                state_q <= S_TAIL;
              end
            end
          end
        end
        S_TAIL: begin
          phase_q <= phase_q + 2'd1;
          if (phase_q == 2'd3) begin
            state_q <= S_IDLE;
            rd_q    <= 1'b0;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign spi_sclk = (state_q == S_XFER) & phase_q[1];
  assign spi_mosi = busy & ~rd_q & sh_q[7];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign spi_cs_n[g] = ~(busy && (cs_act_q == CSW'(g)));
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr && aligned) begin
      if (in_fifo) begin
        for (int l = 0; l < 4; l++)
          bus_rdata[8*l +: 8] = fifo_mem[PW'({bus_addr[6:2], 2'b00} + l)];
      end else begin
        case (word)
          W_CTRL:  bus_rdata = {busy, 23'b0, opcode_q};
          W_CSEL:  bus_rdata[8 +: CSW] = cs_sel_q;
          W_CNT:   bus_rdata = {rx_cnt_q, 16'b0, tx_cnt_q};
          default: bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              spi_sclk,
  input logic              spi_mosi,
  input logic [NUM_CS-1:0] spi_cs_n
);
  p_cs_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~spi_cs_n) <= 1);

  p_cs_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&spi_cs_n));

  p_cs_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(spi_cs_n));

  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (&spi_cs_n) |-> !spi_sclk);

  p_sclk_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |=> spi_sclk);

  p_sclk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> ##2 !spi_sclk);

  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
);

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi;
  logic        miso_q = 1'b0;
  logic [3:0]  spi_cs_n;

  spi_cmd_engine u_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(miso_q), .spi_cs_n(spi_cs_n)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int rises, low_cyc, hi_cyc;
  logic [3:0] low_mask;
  logic [7:0] slave_bytes [16];
  logic [7:0] mosi_bytes [16];

  always @(posedge spi_sclk) begin
    automatic int k = rises;
    if (k < 128) mosi_bytes[k/8][7-(k%8)] = spi_mosi;
    rises = k + 1;
    miso_q = (rises < 128) ? slave_bytes[rises/8][7-(rises%8)] : 1'b0;
  end

  always @(negedge clk) begin
    if (spi_cs_n != 4'hF) begin
      low_cyc = low_cyc + 1;
      low_mask = low_mask | ~spi_cs_n;
    end
    if (spi_sclk) hi_cyc = hi_cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic mon_clear();
    rises = 0; low_cyc = 0; hi_cyc = 0; low_mask = '0;
    for (int i = 0; i < 16; i++) mosi_bytes[i] = '0;
    miso_q = slave_bytes[0][7];
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      bus_read(8'h00, d);
      if (!d[31]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(spi_cs_n == 4'hF, "R1 cs idle", {28'b0, spi_cs_n}, 32'hF);
    chk(spi_sclk == 1'b0, "R1 sclk idle", {31'b0, spi_sclk}, 0);
    bus_read(8'h00, d); chk(d == 0, "R1 ctrl", d, 0);
    bus_read(8'h48, d); chk(d == 0, "R1 counts", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_write(8'h00, 32'h0010_009F, 4'b0101);
    bus_read(8'h00, d); chk(d == 32'h9F, "R2 opcode, clear bit reads 0", d, 32'h9F);
    bus_write(8'h1C, 32'h0000_0200, 4'b0010);
    bus_read(8'h1C, d); chk(d == 32'h200, "R2 device index", d, 32'h200);
    bus_write(8'h48, 32'h7B00_0042, 4'b1001);
    bus_read(8'h48, d); chk(d == 32'h7B00_0042, "R2 counts", d, 32'h7B00_0042);
  endtask

  task automatic t_lanes();
    logic [31:0] d;
    bus_write(8'h80, 32'h4433_2211, 4'b1111);
    bus_write(8'h80, 32'h00AA_0000, 4'b0100);
    bus_read(8'h80, d); chk(d == 32'h44AA_2211, "R10 lane write", d, 32'h44AA_2211);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    bus_write(8'h80, 32'h0056_3412, 4'b0111);
    bus_write(8'h48, 32'h0200_0003, 4'b1001);
    bus_write(8'h1C, 32'h0000_0100, 4'b0010);
    slave_bytes[4] = 8'hA5; slave_bytes[5] = 8'h3C;
    mon_clear();
    bus_write(8'h00, 32'h0011_0003, 4'b0101);
    bus_read(8'h00, d); chk(d[31] == 1'b1, "R3 busy set", d, 32'h8000_0003);
    wait_idle();
    chk(rises == 48, "R5 rising edges", rises, 48);
    chk(hi_cyc == 96, "R5 high time", hi_cyc, 96);
    chk(low_cyc == 200, "R5 cs low span", low_cyc, 200);
    chk(low_mask == 4'b0010, "R7 device 1 only", low_mask, 4'b0010);
    chk({mosi_bytes[0], mosi_bytes[1], mosi_bytes[2], mosi_bytes[3]} == 32'h0312_3456,
        "R4 send order", {mosi_bytes[0], mosi_bytes[1], mosi_bytes[2], mosi_bytes[3]}, 32'h0312_3456);
    chk({mosi_bytes[4], mosi_bytes[5]} == 16'h0, "R4 data low in reply", {mosi_bytes[4], mosi_bytes[5]}, 0);
    bus_read(8'h80, d); chk(d == 32'hA556_3412, "R6 reply placement", d, 32'hA556_3412);
    bus_read(8'h84, d); chk(d[7:0] == 8'h3C, "R6 second reply", d[7:0], 8'h3C);
    chk(spi_cs_n == 4'hF && !spi_sclk, "R7 released", {27'b0, spi_sclk, spi_cs_n}, 32'hF);
  endtask

  task automatic t_ptr_continue();
    logic [31:0] d;
    bus_write(8'h84, 32'h0000_7700, 4'b0010);
    bus_write(8'h48, 32'h0100_0001, 4'b1001);
    slave_bytes[2] = 8'hC9;
    mon_clear();
    bus_write(8'h00, 32'h0001_000B, 4'b0101);
    wait_idle();
    chk({mosi_bytes[0], mosi_bytes[1], mosi_bytes[2]} == 24'h0B7700, "R8 continues at index 5",
        {mosi_bytes[0], mosi_bytes[1], mosi_bytes[2]}, 24'h0B7700);
    bus_read(8'h84, d); chk(d[23:16] == 8'hC9, "R8 reply at index 6", d[23:16], 8'hC9);
    chk(low_cyc == 104, "R5 three byte span", low_cyc, 104);
  endtask

  task automatic t_zero_counts();
    logic [31:0] d;
    bus_write(8'h80, 32'h0000_ADDE, 4'b0011);
    bus_write(8'h48, 32'h0000_0002, 4'b1001);
    mon_clear();
    bus_write(8'h00, 32'h0011_0002, 4'b0101);
    wait_idle();
    chk(rises == 24, "R9 no reply phase", rises, 24);
    chk({mosi_bytes[0], mosi_bytes[1], mosi_bytes[2]} == 24'h02DEAD, "R9 send bytes",
        {mosi_bytes[0], mosi_bytes[1], mosi_bytes[2]}, 24'h02DEAD);
    bus_read(8'h80, d); chk(d[23:16] == 8'h56, "R9 buffer untouched", d[23:16], 8'h56);
    bus_write(8'h48, 32'h0100_0000, 4'b1001);
    slave_bytes[1] = 8'h81;
    mon_clear();
    bus_write(8'h00, 32'h0011_0005, 4'b0101);
    wait_idle();
    chk(rises == 16, "R9 straight to reply", rises, 16);
    chk(mosi_bytes[0] == 8'h05, "R9 command byte", mosi_bytes[0], 8'h05);
    bus_read(8'h80, d); chk(d[7:0] == 8'h81, "R6 reply at index 0", d[7:0], 8'h81);
  endtask

  task automatic t_cs_and_restart();
    bus_write(8'h1C, 32'h0000_0300, 4'b0010);
    bus_write(8'h48, 32'h0000_0000, 4'b1001);
    mon_clear();
    bus_write(8'h00, 32'h0011_005A, 4'b0101);
    repeat (10) @(negedge clk);
    bus_write(8'h00, 32'h0001_00C3, 4'b0101);
    wait_idle();
    chk(low_mask == 4'b1000, "R7 device 3 only", low_mask, 4'b1000);
    chk(rises == 8, "R3 start while busy ignored", rises, 8);
    chk(mosi_bytes[0] == 8'h5A, "R3 command byte kept", mosi_bytes[0], 8'h5A);
    chk(low_cyc == 40, "R3 single command span", low_cyc, 40);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) slave_bytes[i] = '0;
    rises = 0; low_cyc = 0; hi_cyc = 0; low_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_lanes();
    t_basic();
    t_ptr_continue();
    t_zero_counts();
    t_cs_and_restart();
    report();
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end
endmodule